// File: doc/BRIEF.md
# TFT Panel Raster Timing Generator

This block produces the raster control signals a TFT panel needs: a horizontal sync, a vertical sync, a data-enable strobe and an optional one-clock line-end marker. It also passes one pixel word through to the panel, gated by the data-enable window. Every line is split into four phases: sync, back porch, active and front porch. Each phase lasts a programmed number of pixel clocks. Every frame is split into the same four phases, counted in whole lines.

Each timing field holds its length minus one, so a field value of N gives N+1 clocks or lines. The fields are captured into a shadow register at each frame boundary, and continuously while video is off. A field rewritten in the middle of a frame therefore takes effect only from the next frame.

Each of the five panel-facing signals has its own polarity-invert bit, which acts on the pin directly. Status outputs report the current horizontal phase, the current vertical phase and the index of the active line. A sampling-edge select is retimed with the other outputs so that panel-side logic can choose which pixel-clock edge captures the data.

Top module: `lcd_tmg_gen`

## Requirements
- R1: While rst_n is low, and from the second rising edge after video_en is seen low, the active levels of hsync, vsync, de and lend are all 0. Each pin then equals its invert bit, pix_out equals inv_data replicated, and h_stat, v_stat and line_cnt are 0.
- R2: If video_en is low and is then first sampled high at rising edge k, hsync is still inactive after edge k and becomes active after edge k+1.
- R3: A line runs through the horizontal phases for cfg_hsw+1, cfg_hbp+1, cfg_hact+1 and cfg_hfp+1 clocks in turn. hsync is active during the sync phase.
- R4: vsync is active for cfg_vsw+1 lines and inactive for the remaining lines of a frame, whose length is the sum of the four vertical fields plus 4 lines. vsync becomes active in the same clock in which hsync becomes active.
- R5: de is active only when both phases are active. A frame holds exactly cfg_vact+1 data-enable pulses.
- R6: The status codes h_stat and v_stat use 0 for sync, 1 for back porch, 2 for active and 3 for front porch. They move only from code c to (c+1) mod 4, and they are aligned in time with hsync, vsync and de.
- R7: During the vertical active phase, line_cnt gives the 0-based index of the current active line. Outside that phase it is 0.
- R8: When lend_en is 1, lend is active for exactly one clock, in the first front-porch clock of every line. When lend_en is 0, lend is never active.
- R9: The bits inv_hsync, inv_vsync, inv_de, inv_lend and inv_data invert their pins combinationally. A value of 1 makes the signal active-low.
- R10: pix_out equals pix_in, captured in the same cycle as the de decision, while de is active. Otherwise it equals zero, XOR inv_data.
- R11: pclk_fall repeats clk_fall_sel with one clock of latency. A value of 1 means the data is to be captured on the falling pixel-clock edge.
- R12: Timing fields written during a running frame do not alter that frame. They apply from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| video_en | input | 1 | Enables all raster activity |
| cfg_hsw | input | 8 | Horizontal sync length minus one |
| cfg_hbp | input | 7 | Horizontal back porch minus one |
| cfg_hact | input | 11 | Active pixels per line minus one |
| cfg_hfp | input | 8 | Horizontal front porch minus one |
| cfg_vsw | input | 6 | Vertical sync length in lines minus one |
| cfg_vbp | input | 8 | Vertical back porch lines minus one |
| cfg_vact | input | 10 | Active lines minus one |
| cfg_vfp | input | 8 | Vertical front porch lines minus one |
| inv_hsync | input | 1 | Invert hsync pin |
| inv_vsync | input | 1 | Invert vsync pin |
| inv_de | input | 1 | Invert de pin |
| inv_lend | input | 1 | Invert lend pin |
| inv_data | input | 1 | Invert pix_out bits |
| lend_en | input | 1 | Enable the line-end pulse |
| clk_fall_sel | input | 1 | Sampling-edge select, 1 selects the falling edge |
| pix_in | input | 16 | Pixel word to present |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| lend | output | 1 | Line-end pulse |
| pix_out | output | 16 | Gated pixel data |
| pclk_fall | output | 1 | Retimed sampling-edge select |
| h_stat | output | 2 | Horizontal phase code |
| v_stat | output | 2 | Vertical phase code |
| line_cnt | output | 10 | Active line index |

## Verification
Two events share the last clock of a frame: the horizontal and vertical counters wrap, and the shadow registers capture new timing fields. The bench rewrites the active width just after vsync becomes active, when the capture for that frame has already happened. It then measures the data-enable pulse width. The width must keep its old value for the rest of that frame and change only after the next vsync edge. The start of vsync must also fall in the same clock as the start of hsync, and the bench checks this by sampling both pins at that boundary.

// File: rtl/lcd_tmg_pkg.sv
// Shared types and helpers for the raster timing generator.
package lcd_tmg_pkg;

  // Phase codes; the numeric order is also the order of traversal.
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  function automatic int wmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_tmg_cfg.sv
// Shadow register for the timing fields: it captures only when load is high.
module lcd_tmg_cfg #(
  parameter int W = 66
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= q_d;
  end

  // Fields must not move while a frame is running.
  p_shadow_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

endmodule

// File: rtl/lcd_tmg_axis.sv
// One raster axis: a four-phase sequencer with a count inside each phase.
module lcd_tmg_axis
  import lcd_tmg_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] len_sync,
  input  logic [CNT_W-1:0] len_back,
  input  logic [CNT_W-1:0] len_act,
  input  logic [CNT_W-1:0] len_front,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cur_len;
  logic             at_end;
  logic             upd;

  always_comb begin
    unique case (phase)
      PH_SYNC:  cur_len = len_sync;
      PH_BACK:  cur_len = len_back;
      PH_ACT:   cur_len = len_act;
      default:  cur_len = len_front;
    endcase
  end

  assign at_end = (cnt == cur_len);
  assign last   = (phase == PH_FRONT) && at_end;
  assign upd    = clr || step;

  always_comb begin
    phase_d = phase;
    cnt_d   = cnt;
    if (clr) begin
      phase_d = PH_SYNC;
      cnt_d   = '0;
    end else if (step) begin
      if (at_end) begin
        phase_d = phase_e'(2'(phase + 2'd1));
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (upd) begin
      phase <= phase_d;
      cnt   <= cnt_d;
    end
  end

  logic [1:0] ph_bits;
  assign ph_bits = phase;

  // The count never passes the length of the phase it is in.
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cur_len);

  // The phase only ever moves one step forward.
  p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (ph_bits == $past(ph_bits)) ||
                       (ph_bits == 2'($past(ph_bits) + 2'd1)));

  // Without a step or a clear, the axis holds its state.
  p_axis_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(cnt) && $stable(ph_bits));

endmodule

// File: rtl/lcd_tmg_out.sv
// Output stage: it registers the decoded raster signals and status, and applies the invert bits at the pins.
module lcd_tmg_out
  import lcd_tmg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LCNT_W = 10,
  parameter int VC_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  phase_e            h_phase,
  input  phase_e            v_phase,
  input  logic [VC_W-1:0]   v_cnt,
  input  logic              h_first,
  input  logic              lend_en,
  input  logic              inv_hsync,
  input  logic              inv_vsync,
  input  logic              inv_de,
  input  logic              inv_lend,
  input  logic              inv_data,
  input  logic              clk_fall_sel,
  input  logic [DATA_W-1:0] pix_in,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              lend,
  output logic [DATA_W-1:0] pix_out,
  output logic              pclk_fall,
  output logic [1:0]        h_stat,
  output logic [1:0]        v_stat,
  output logic [LCNT_W-1:0] line_cnt
);

  logic              hs_d, vs_d, de_d, le_d, fall_d;
  logic              hs_q, vs_q, de_q, le_q, fall_q;
  logic [DATA_W-1:0] pix_d, pix_q;
  phase_e            hst_d, vst_d, hst_q, vst_q;
  logic [LCNT_W-1:0] lcnt_d, lcnt_q;

  always_comb begin
    hs_d   = run && (h_phase == PH_SYNC);
    vs_d   = run && (v_phase == PH_SYNC);
    de_d   = run && (h_phase == PH_ACT) && (v_phase == PH_ACT);
    le_d   = run && lend_en && (h_phase == PH_FRONT) && h_first;
    pix_d  = de_d ? pix_in : '0;
    hst_d  = run ? h_phase : PH_SYNC;
    vst_d  = run ? v_phase : PH_SYNC;
    lcnt_d = (run && (v_phase == PH_ACT)) ? v_cnt[LCNT_W-1:0] : '0;
    fall_d = clk_fall_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      de_q   <= 1'b0;
      le_q   <= 1'b0;
      pix_q  <= '0;
      hst_q  <= PH_SYNC;
      vst_q  <= PH_SYNC;
      lcnt_q <= '0;
      fall_q <= 1'b0;
    end else begin
      hs_q   <= hs_d;
      vs_q   <= vs_d;
      de_q   <= de_d;
      le_q   <= le_d;
      pix_q  <= pix_d;
      hst_q  <= hst_d;
      vst_q  <= vst_d;
      lcnt_q <= lcnt_d;
      fall_q <= fall_d;
    end
  end

  assign hsync     = hs_q ^ inv_hsync;
  assign vsync     = vs_q ^ inv_vsync;
  assign de        = de_q ^ inv_de;
  assign lend      = le_q ^ inv_lend;
  assign pix_out   = pix_q ^ {DATA_W{inv_data}};
  assign pclk_fall = fall_q;
  assign h_stat    = hst_q;
  assign v_stat    = vst_q;
  assign line_cnt  = lcnt_q;

  // When video is off, every raster signal goes quiet one clock later.
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !hs_q && !vs_q && !de_q && !le_q);

  // The line-end marker is a single-clock pulse.
  p_lend_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    le_q |=> !le_q);

  // Data enable appears only inside both active windows.
  p_de_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    de_q |-> (hst_q == PH_ACT) && (vst_q == PH_ACT));

  // The line index is zero outside the vertical active window.
  p_line_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vst_q != PH_ACT) |-> (lcnt_q == '0));

endmodule

// File: rtl/lcd_tmg_gen.sv
// Top level of the raster timing generator.
module lcd_tmg_gen
  import lcd_tmg_pkg::*;
#(
  parameter int HSW_W  = 8,
  parameter int HBP_W  = 7,
  parameter int HACT_W = 11,
  parameter int HFP_W  = 8,
  parameter int VSW_W  = 6,
  parameter int VBP_W  = 8,
  parameter int VACT_W = 10,
  parameter int VFP_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              video_en,
  input  logic [HSW_W-1:0]  cfg_hsw,
  input  logic [HBP_W-1:0]  cfg_hbp,
  input  logic [HACT_W-1:0] cfg_hact,
  input  logic [HFP_W-1:0]  cfg_hfp,
  input  logic [VSW_W-1:0]  cfg_vsw,
  input  logic [VBP_W-1:0]  cfg_vbp,
  input  logic [VACT_W-1:0] cfg_vact,
  input  logic [VFP_W-1:0]  cfg_vfp,
  input  logic              inv_hsync,
  input  logic              inv_vsync,
  input  logic              inv_de,
  input  logic              inv_lend,
  input  logic              inv_data,
  input  logic              lend_en,
  input  logic              clk_fall_sel,
  input  logic [DATA_W-1:0] pix_in,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              lend,
  output logic [DATA_W-1:0] pix_out,
  output logic              pclk_fall,
  output logic [1:0]        h_stat,
  output logic [1:0]        v_stat,
  output logic [VACT_W-1:0] line_cnt
);

  localparam int H_CNT_W = wmax(wmax(HSW_W, HBP_W), wmax(HACT_W, HFP_W));
  localparam int V_CNT_W = wmax(wmax(VSW_W, VBP_W), wmax(VACT_W, VFP_W));
  localparam int CFG_W   = HSW_W + HBP_W + HACT_W + HFP_W +
                           VSW_W + VBP_W + VACT_W + VFP_W;

  // Run flag: video_en retimed; the counters advance only while it is set.
  logic run_q, run_d;
  always_comb run_d = video_en;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  // Shadowed timing fields.
  logic [CFG_W-1:0]  cfg_d, cfg_q;
  logic [HSW_W-1:0]  sh_hsw;
  logic [HBP_W-1:0]  sh_hbp;
  logic [HACT_W-1:0] sh_hact;
  logic [HFP_W-1:0]  sh_hfp;
  logic [VSW_W-1:0]  sh_vsw;
  logic [VBP_W-1:0]  sh_vbp;
  logic [VACT_W-1:0] sh_vact;
  logic [VFP_W-1:0]  sh_vfp;
  logic              cfg_load;

  assign cfg_d = {cfg_hsw, cfg_hbp, cfg_hact, cfg_hfp,
                  cfg_vsw, cfg_vbp, cfg_vact, cfg_vfp};
  assign {sh_hsw, sh_hbp, sh_hact, sh_hfp,
          sh_vsw, sh_vbp, sh_vact, sh_vfp} = cfg_q;

  // Axis state.
  phase_e               h_phase, v_phase;
  logic [H_CNT_W-1:0]   h_cnt;
  logic [V_CNT_W-1:0]   v_cnt;
  logic                 h_last, v_last;
  logic                 axis_clr, h_step, v_step, frame_end;

  assign axis_clr  = !video_en;
  assign h_step    = run_q;
  assign v_step    = run_q && h_last;
  assign frame_end = run_q && h_last && v_last;
  assign cfg_load  = !run_q || frame_end;

  lcd_tmg_cfg #(.W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .d     (cfg_d),
    .q     (cfg_q)
  );

  lcd_tmg_axis #(.CNT_W(H_CNT_W)) u_h_axis (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (axis_clr),
    .step      (h_step),
    .len_sync  (H_CNT_W'(sh_hsw)),
    .len_back  (H_CNT_W'(sh_hbp)),
    .len_act   (H_CNT_W'(sh_hact)),
    .len_front (H_CNT_W'(sh_hfp)),
    .phase     (h_phase),
    .cnt       (h_cnt),
    .last      (h_last)
  );

  lcd_tmg_axis #(.CNT_W(V_CNT_W)) u_v_axis (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (axis_clr),
    .step      (v_step),
    .len_sync  (V_CNT_W'(sh_vsw)),
    .len_back  (V_CNT_W'(sh_vbp)),
    .len_act   (V_CNT_W'(sh_vact)),
    .len_front (V_CNT_W'(sh_vfp)),
    .phase     (v_phase),
    .cnt       (v_cnt),
    .last      (v_last)
  );

  logic h_first;
  assign h_first = (h_cnt == '0);

  lcd_tmg_out #(
    .DATA_W (DATA_W),
    .LCNT_W (VACT_W),
    .VC_W   (V_CNT_W)
  ) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run_q),
    .h_phase      (h_phase),
    .v_phase      (v_phase),
    .v_cnt        (v_cnt),
    .h_first      (h_first),
    .lend_en      (lend_en),
    .inv_hsync    (inv_hsync),
    .inv_vsync    (inv_vsync),
    .inv_de       (inv_de),
    .inv_lend     (inv_lend),
    .inv_data     (inv_data),
    .clk_fall_sel (clk_fall_sel),
    .pix_in       (pix_in),
    .hsync        (hsync),
    .vsync        (vsync),
    .de           (de),
    .lend         (lend),
    .pix_out      (pix_out),
    .pclk_fall    (pclk_fall),
    .h_stat       (h_stat),
    .v_stat       (v_stat),
    .line_cnt     (line_cnt)
  );

  // The vertical axis wraps only together with the horizontal axis.
  p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && v_last && !h_last && video_en) |=> (v_phase == PH_FRONT));

endmodule

// File: tb/lcd_tmg_gen_tb.sv
`timescale 1ns/1ps
module lcd_tmg_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        video_en = 1'b0;
  logic [7:0]  cfg_hsw = 8'd1;
  logic [6:0]  cfg_hbp = 7'd2;
  logic [10:0] cfg_hact = 11'd7;
  logic [7:0]  cfg_hfp = 8'd3;
  logic [5:0]  cfg_vsw = 6'd0;
  logic [7:0]  cfg_vbp = 8'd1;
  logic [9:0]  cfg_vact = 10'd3;
  logic [7:0]  cfg_vfp = 8'd1;
  logic        inv_hsync = 1'b0, inv_vsync = 1'b0, inv_de = 1'b0;
  logic        inv_lend = 1'b0, inv_data = 1'b0;
  logic        lend_en = 1'b0, clk_fall_sel = 1'b0;
  logic [15:0] pix_in = 16'hA5C3;

  logic        hsync, vsync, de, lend, pclk_fall;
  logic [15:0] pix_out;
  logic [1:0]  h_stat, v_stat;
  logic [9:0]  line_cnt;

  // Timing implied by the configuration above: 17 clocks per line, 9 lines per frame.
  localparam int LINE_CLK  = 17;
  localparam int FRAME_CLK = 153;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lcd_tmg_gen u_dut (
    .clk(clk), .rst_n(rst_n), .video_en(video_en),
    .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp),
    .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
    .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_de(inv_de),
    .inv_lend(inv_lend), .inv_data(inv_data), .lend_en(lend_en),
    .clk_fall_sel(clk_fall_sel), .pix_in(pix_in),
    .hsync(hsync), .vsync(vsync), .de(de), .lend(lend), .pix_out(pix_out),
    .pclk_fall(pclk_fall), .h_stat(h_stat), .v_stat(v_stat), .line_cnt(line_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Active level of a raster signal, with the bench's own invert setting removed.
  function automatic logic act_of(input int sel);
    case (sel)
      0:       return hsync ^ inv_hsync;
      1:       return vsync ^ inv_vsync;
      2:       return de ^ inv_de;
      default: return lend ^ inv_lend;
    endcase
  endfunction

  task automatic run_len(input int sel, input logic lvl, output int n);
    n = 0;
    while (act_of(sel) == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_for(input int sel, input logic lvl);
    int d;
    run_len(sel, ~lvl, d);
  endtask

  task automatic sync_frame();
    wait_for(1, 1'b0);
    wait_for(1, 1'b1);
  endtask

  task automatic t_reset();
    chk(hsync == 0 && vsync == 0 && de == 0 && lend == 0, "R1 pins in reset", {hsync, vsync, de, lend}, 0);
    chk(pix_out == 0, "R1 pix in reset", pix_out, 0);
    chk(h_stat == 0 && v_stat == 0 && line_cnt == 0, "R1 status in reset", {h_stat, v_stat}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(hsync == 0 && de == 0 && vsync == 0, "R1 idle after reset", {hsync, vsync, de}, 0);
  endtask

  task automatic t_restart();
    video_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(h_stat == 0 && line_cnt == 0 && act_of(2) == 0, "R1 idle when disabled", h_stat, 0);
    video_en = 1'b1;
    @(negedge clk);
    chk(act_of(0) == 0, "R2 hsync quiet after first edge", act_of(0), 0);
    @(negedge clk);
    chk(act_of(0) == 1, "R2 hsync active after second edge", act_of(0), 1);
  endtask

  task automatic t_hline();
    int n;
    sync_frame();
    wait_for(2, 1'b1);
    chk(h_stat == 2 && v_stat == 2, "R6 status in active", {h_stat, v_stat}, 10);
    chk(pix_out == pix_in, "R10 pix passes in de", pix_out, pix_in);
    run_len(2, 1'b1, n);  chk(n == 8, "R3 active length", n, 8);
    chk(pix_out == 0, "R10 pix zero outside de", pix_out, 0);
    run_len(0, 1'b0, n);  chk(n == 4, "R3 front porch length", n, 4);
    run_len(0, 1'b1, n);  chk(n == 2, "R3 sync length", n, 2);
    run_len(2, 1'b0, n);  chk(n == 3, "R3 back porch length", n, 3);
  endtask

  task automatic t_vframe();
    int n;
    sync_frame();
    chk(act_of(0) == 1, "R4 hsync starts with vsync", act_of(0), 1);
    chk(v_stat == 0, "R6 vertical sync code", v_stat, 0);
    run_len(1, 1'b1, n);  chk(n == LINE_CLK, "R4 vsync width", n, LINE_CLK);
    run_len(1, 1'b0, n);  chk(n == FRAME_CLK - LINE_CLK, "R4 vsync gap", n, FRAME_CLK - LINE_CLK);
  endtask

  task automatic t_scan();
    int de_rises = 0, lends = 0, bad5 = 0, bad6 = 0, bad7 = 0, bad8 = 0;
    logic       prev_de;
    logic [1:0] prev_h;
    lend_en = 1'b1;
    sync_frame();
    prev_de = act_of(2);
    prev_h  = h_stat;
    for (int i = 0; i < FRAME_CLK; i++) begin
      if (act_of(2) && !prev_de) begin
        if (line_cnt != 10'(de_rises)) bad7++;
        de_rises++;
      end
      if (act_of(2) && (h_stat != 2 || v_stat != 2)) bad5++;
      if (v_stat != 2 && line_cnt != 0) bad7++;
      if (h_stat != prev_h && h_stat != 2'(prev_h + 2'd1)) bad6++;
      if (act_of(3)) begin
        lends++;
        if (h_stat != 3 || prev_h != 2) bad8++;
      end
      prev_de = act_of(2);
      prev_h  = h_stat;
      @(negedge clk);
    end
    chk(de_rises == 4, "R5 de pulses per frame", de_rises, 4);
    chk(bad5 == 0, "R5 de only in both active", bad5, 0);
    chk(bad6 == 0, "R6 phase order", bad6, 0);
    chk(bad7 == 0, "R7 line index", bad7, 0);
    chk(lends == 9, "R8 one lend per line", lends, 9);
    chk(bad8 == 0, "R8 lend at first front porch clock", bad8, 0);
    lend_en = 1'b0;
    sync_frame();
    lends = 0;
    for (int i = 0; i < FRAME_CLK; i++) begin
      if (act_of(3)) lends++;
      @(negedge clk);
    end
    chk(lends == 0, "R8 lend disabled", lends, 0);
  endtask

  task automatic t_polarity();
    video_en = 1'b0;
    repeat (3) @(negedge clk);
    inv_hsync = 1; inv_vsync = 1; inv_de = 1; inv_lend = 1; inv_data = 1;
    #1;
    chk(hsync && vsync && de && lend, "R9 inverted idle pins", {hsync, vsync, de, lend}, 15);
    chk(pix_out == 16'hFFFF, "R1 idle pix inverted", pix_out, 16'hFFFF);
    inv_hsync = 0; inv_vsync = 0; inv_de = 0; inv_lend = 0; inv_data = 0;
    #1;
    chk(!hsync && !vsync && !de && !lend, "R9 plain idle pins", {hsync, vsync, de, lend}, 0);
    inv_hsync = 1; inv_vsync = 1; inv_de = 1; inv_lend = 1; inv_data = 1;
    video_en = 1'b1;
    sync_frame();
    chk(hsync == 0 && vsync == 0, "R9 active-low syncs", {hsync, vsync}, 0);
    wait_for(2, 1'b1);
    chk(de == 0, "R9 active-low de", de, 0);
    chk(pix_out == ~pix_in, "R10 inverted data", pix_out, ~pix_in);
    @(negedge clk);
    inv_hsync = 0; inv_vsync = 0; inv_de = 0; inv_lend = 0; inv_data = 0;
  endtask

  task automatic t_edge();
    @(negedge clk); clk_fall_sel = 1'b1;
    #1; chk(pclk_fall == 0, "R11 latency", pclk_fall, 0);
    @(negedge clk); chk(pclk_fall == 1, "R11 falling selected", pclk_fall, 1);
    clk_fall_sel = 1'b0;
    @(negedge clk); chk(pclk_fall == 0, "R11 rising selected", pclk_fall, 0);
  endtask

  task automatic t_midframe();
    int n;
    sync_frame();
    cfg_hact = 11'd3;
    wait_for(2, 1'b1);
    run_len(2, 1'b1, n); chk(n == 8, "R12 frame keeps old width", n, 8);
    sync_frame();
    wait_for(2, 1'b1);
    run_len(2, 1'b1, n); chk(n == 4, "R12 next frame uses new width", n, 4);
    cfg_hact = 11'd7;
    sync_frame();
    wait_for(2, 1'b1);
    run_len(2, 1'b1, n); chk(n == 8, "R12 restored width", n, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_restart();
    t_hline();
    t_vframe();
    t_scan();
    t_polarity();
    t_edge();
    t_midframe();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule